// File: doc/BRIEF.md
# Parallel 8-bit Panel Bus Master

This block connects an internal host to an LCD or OLED panel that uses an 80-series parallel CPU bus. The host hands over one request at a time through a valid/ready port. There are four kinds of request: write to the index register, write register or pixel data, read the status register, and read pixel memory. For each request the block drives the chip-select, register-select and read or write strobe, and runs the 8-bit data bus through separate output, output-enable and input pins. When a read completes, the block returns the captured byte with a one-cycle done pulse.

Every strobe phase lasts a fixed number of system-clock cycles, set by parameters. The defaults assume a 48 MHz clock: 9 cycles write-low, 5 write-high, 15 read-low and 15 read-high. These counts are the panel's nanosecond minimums rounded up. Write data is driven from the first cycle of the low phase, so it is set up well before the strobe rises. After reset the block holds the panel reset output low for a fixed number of cycles and accepts no request until that pulse is over.

Top module: `lcd80_master`

## Requirements
- R1: While `rst_n` is low, and for `RST_LO` cycles after it is released, `pnl_res_n` is low, `pnl_cs_n`, `pnl_rd_n` and `pnl_wr_n` are high, `pnl_doe` is low and `req_ready` is low. After that `pnl_res_n` stays high.
- R2: `req_op` bit 1 gives the register-select level and bit 0 chooses a read (1) or a write (0). This gives 00 = index write, 01 = status read, 10 = data write, 11 = pixel read. `pnl_rs` holds that level for the whole bus cycle, which is every cycle in which `pnl_cs_n` is low.
- R3: A write request drives `pnl_wr_n` low for exactly `WR_LO` cycles, starting the cycle after acceptance. It then keeps `pnl_wr_n` high with `pnl_cs_n` still low for `WR_HI` cycles, and then raises `pnl_cs_n`. `pnl_rd_n` stays high throughout.
- R4: A read request drives `pnl_rd_n` low for exactly `RD_LO` cycles, starting the cycle after acceptance. It then keeps `pnl_rd_n` high with `pnl_cs_n` low for `RD_HI` cycles. `pnl_wr_n` stays high throughout.
- R5: `pnl_doe` is high exactly during the low and high phases of a write, and `pnl_dout` then equals the accepted `req_wdata`. During reads, idle and reset `pnl_doe` is low.
- R6: For a read, `pnl_din` is captured at the clock edge that ends the last read-low cycle. `rsp_valid` is high for exactly one cycle, the first read-high cycle, with that byte on `rsp_rdata`. Writes never raise `rsp_valid`.
- R7: `req_ready` is high only when no bus cycle or reset pulse is in progress. A request held valid during a bus cycle is accepted only after the high phase ends. Between two bus cycles `pnl_cs_n` is high for at least one cycle.
- R8: `pnl_rd_n` and `pnl_wr_n` are never low together, and both are high whenever `pnl_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Bit 1 = register-select level, bit 0 = read |
| req_wdata | input | DW | Byte to write |
| rsp_valid | output | 1 | One-cycle read-done pulse |
| rsp_rdata | output | DW | Byte captured by the last read |
| pnl_cs_n | output | 1 | Panel chip select, active low |
| pnl_rs | output | 1 | Panel register select |
| pnl_rd_n | output | 1 | Panel read strobe, active low |
| pnl_wr_n | output | 1 | Panel write strobe, active low |
| pnl_res_n | output | 1 | Panel reset, active low |
| pnl_dout | output | DW | Data bus output value |
| pnl_doe | output | 1 | Data bus output enable |
| pnl_din | input | DW | Data bus input value |

## Verification
A request accepted at one clock edge drives its strobe low from the next cycle on. The strobe then stays low for the low-phase count and high for the high-phase count, and `req_ready` returns one cycle after the high phase. The read byte and the done pulse appear in the cycle after the last low cycle, and the panel reset pulse ends `RST_LO` cycles after reset is released. At each acceptance the bench pushes one expected entry per future cycle into a queue and pops one at every falling edge to compare against all outputs. The bench drives `pnl_din` with a value that changes every cycle, so a capture that is one edge early or late gives the wrong byte.

// File: rtl/lcd80_master.sv
module lcd80_master #(
  parameter int DW     = 8,
  parameter int WR_LO  = 9,
  parameter int WR_HI  = 5,
  parameter int RD_LO  = 15,
  parameter int RD_HI  = 15,
  parameter int RST_LO = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          pnl_cs_n,
  output logic          pnl_rs,
  output logic          pnl_rd_n,
  output logic          pnl_wr_n,
  output logic          pnl_res_n,
  output logic [DW-1:0] pnl_dout,
  output logic          pnl_doe,
  input  logic [DW-1:0] pnl_din
);

  localparam int M_W   = (WR_LO > WR_HI) ? WR_LO : WR_HI;
  localparam int M_R   = (RD_LO > RD_HI) ? RD_LO : RD_HI;
  localparam int M_WR  = (M_W > M_R) ? M_W : M_R;
  localparam int M_ALL = (M_WR > RST_LO) ? M_WR : RST_LO;
  localparam int CW    = $clog2(M_ALL + 1);

  typedef enum logic [1:0] {ST_RST, ST_IDLE, ST_LO, ST_HI} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          op_rd;
  logic          op_rs;
  logic [DW-1:0] wdat;
  logic          cnt_done;

  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_RST;
      cnt       <= CW'(RST_LO - 1);
      op_rd     <= 1'b0;
      op_rs     <= 1'b0;
      wdat      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_RST: begin
          if (cnt_done) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (req_valid) begin
            st    <= ST_LO;
            op_rd <= req_op[0];
            op_rs <= req_op[1];
            wdat  <= req_wdata;
            cnt   <= req_op[0] ? CW'(RD_LO - 1) : CW'(WR_LO - 1);
          end
        end
        ST_LO: begin
          if (cnt_done) begin
            st  <= ST_HI;
            cnt <= op_rd ? CW'(RD_HI - 1) : CW'(WR_HI - 1);
            if (op_rd) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= pnl_din;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HI: begin
          if (cnt_done) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= ST_RST;
      endcase
    end
  end

  wire busy = (st == ST_LO) || (st == ST_HI);

  assign req_ready = (st == ST_IDLE);
  assign pnl_res_n = (st != ST_RST);
  assign pnl_cs_n  = !busy;
  assign pnl_rs    = busy && op_rs;
  assign pnl_rd_n  = !((st == ST_LO) && op_rd);
  assign pnl_wr_n  = !((st == ST_LO) && !op_rd);
  assign pnl_doe   = busy && !op_rd;
  assign pnl_dout  = wdat;

endmodule

// File: rtl/lcd80_master_chk.sv
module lcd80_master_chk #(
  parameter int WR_LO = 9,
  parameter int RD_LO = 15
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rs,
  input logic rd_n,
  input logic wr_n,
  input logic res_n,
  input logic doe,
  input logic rsp_valid,
  input logic req_ready
);

  int wlo;
  int rlo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlo <= 0;
      rlo <= 0;
    end else begin
      wlo <= wr_n ? 0 : wlo + 1;
      rlo <= rd_n ? 0 : rlo + 1;
    end
  end

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_n == 1'b0 && wr_n == 1'b0));
  p_cs_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (rd_n && wr_n));
  p_res_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_n |-> (cs_n && !req_ready && !doe));
  p_rs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(rs));
  p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (wlo == WR_LO));
  p_rd_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rlo == RD_LO));
  p_oe_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> (!cs_n && rd_n));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_done_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rd_n && $past(!rd_n)));
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && res_n));

endmodule

bind lcd80_master lcd80_master_chk #(.WR_LO(WR_LO), .RD_LO(RD_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(pnl_cs_n), .rs(pnl_rs), .rd_n(pnl_rd_n),
  .wr_n(pnl_wr_n), .res_n(pnl_res_n), .doe(pnl_doe), .rsp_valid(rsp_valid),
  .req_ready(req_ready)
);

// File: tb/test_lcd80_master.sv
module test_lcd80_master;
  localparam int WL = 9, WH = 5, RL = 15, RH = 15, RST = 24;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_wdata = 8'd0;
  logic rsp_valid;
  logic [7:0] rsp_rdata;
  logic pnl_cs_n, pnl_rs, pnl_rd_n, pnl_wr_n, pnl_res_n, pnl_doe;
  logic [7:0] pnl_dout;
  logic [7:0] pnl_din = 8'd0;

  always #5 clk = ~clk;

  lcd80_master i_lcd80_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pnl_cs_n(pnl_cs_n), .pnl_rs(pnl_rs),
    .pnl_rd_n(pnl_rd_n), .pnl_wr_n(pnl_wr_n), .pnl_res_n(pnl_res_n),
    .pnl_dout(pnl_dout), .pnl_doe(pnl_doe), .pnl_din(pnl_din)
  );

  typedef struct packed {
    logic cs_n, rs, rd_n, wr_n, oe, res_n, rdy, rv;
    logic [7:0] wd;
    logic [7:0] rd;
  } ex_t;

  ex_t q[$];
  int checks = 0;
  int errors = 0;

  logic [1:0] ops [N] = '{2'd0, 2'd2, 2'd2, 2'd1, 2'd3, 2'd2, 2'd3, 2'd0};
  logic [7:0] dat [N] = '{8'h2C, 8'h00, 8'hFF, 8'h11, 8'h22, 8'hA5, 8'h33, 8'h36};
  int gaps [N] = '{0, 0, 0, 3, 0, 0, 5, 1};

  function automatic logic [7:0] busval(int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  ex_t idle_e, e;
  int cyc = 0, idx = 0, gap = 0, tail = 0;
  bit acc = 0;

  initial begin
    idle_e = '{cs_n:1'b1, rs:1'b0, rd_n:1'b1, wr_n:1'b1, oe:1'b0, res_n:1'b1,
               rdy:1'b1, rv:1'b0, wd:8'h00, rd:8'h00};
    repeat (3) @(negedge clk);
    // R1 reset state while rst_n low
    chk(!pnl_res_n && pnl_cs_n && pnl_rd_n && pnl_wr_n && !pnl_doe && !req_ready && !rsp_valid,
        "R1", {pnl_res_n, pnl_cs_n, pnl_rd_n, pnl_wr_n, pnl_doe, req_ready}, 6'b011100);
    rst_n = 1'b1;
    for (int k = 0; k < RST - 1; k++) begin
      e = idle_e; e.res_n = 1'b0; e.rdy = 1'b0; q.push_back(e);
    end
    gap = gaps[0];
    while (tail < 6) begin
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin
        chk(1'b0, "watchdog", cyc, 5000);
        break;
      end
      e = (q.size() > 0) ? q.pop_front() : idle_e;
      chk(pnl_res_n === e.res_n, "R1 res_n", pnl_res_n, e.res_n);
      chk(pnl_cs_n === e.cs_n && (e.cs_n || pnl_rs === e.rs), "R2 cs_n/rs",
          {pnl_cs_n, pnl_rs}, {e.cs_n, e.rs});
      chk(pnl_wr_n === e.wr_n, "R3 wr_n", pnl_wr_n, e.wr_n);
      chk(pnl_rd_n === e.rd_n, "R4 rd_n", pnl_rd_n, e.rd_n);
      chk(pnl_doe === e.oe && (!e.oe || pnl_dout === e.wd), "R5 oe/dout",
          {pnl_doe, pnl_dout}, {e.oe, e.wd});
      chk(rsp_valid === e.rv && (!e.rv || rsp_rdata === e.rd), "R6 done/data",
          {rsp_valid, rsp_rdata}, {e.rv, e.rd});
      chk(req_ready === e.rdy, "R7 ready", req_ready, e.rdy);

      if (acc) begin
        idx++;
        req_valid = 1'b0;
        gap = (idx < N) ? gaps[idx] : 0;
        acc = 0;
      end
      if (!req_valid && idx < N) begin
        if (gap > 0) gap--;
        else begin
          req_valid = 1'b1;
          req_op = ops[idx];
          req_wdata = dat[idx];
        end
      end
      pnl_din = busval(cyc);
      if (req_valid && req_ready) begin
        int lo, hi;
        bit rdop;
        rdop = req_op[0];
        lo = rdop ? RL : WL;
        hi = rdop ? RH : WH;
        for (int k = 0; k < lo + hi; k++) begin
          e = '{cs_n:1'b0, rs:req_op[1], rd_n:1'b1, wr_n:1'b1, oe:!rdop, res_n:1'b1,
                rdy:1'b0, rv:1'b0, wd:req_wdata, rd:8'h00};
          if (k < lo) begin
            if (rdop) e.rd_n = 1'b0;
            else      e.wr_n = 1'b0;
          end
          if (rdop && k == lo) begin
            e.rv = 1'b1;
            e.rd = busval(cyc + lo);
          end
          q.push_back(e);
        end
        acc = 1;
      end
      if (idx >= N && q.size() == 0 && !req_valid) tail++;
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule